// File: doc/BRIEF.md
# Fault-Injectable RAM Model

This block is a small single-port, bit-oriented RAM of `2**ADDR_W` one-bit cells. Its reads and writes pass through a selectable functional-fault model instead of behaving as an ideal memory. It serves as a known-defective target, so that march-test engines and built-in self-test controllers can be checked: they must report a pass on a clean array and a failure on every injected defect.

A static configuration selects one fault at a time:
- the fault kind;
- a victim cell;
- an aggressor cell;
- a direction or state bit;
- a forced value.

The configuration may only change in cycles without a write. The fault kinds are:
- stuck-at;
- up or down transition;
- inversion coupling;
- idempotent coupling;
- state coupling;
- a decoder fault in which one address also selects a second cell.

Reads are registered with one cycle of latency. Every cycle performs a read of the addressed cell. A write in the same cycle updates the array after that read.

Top module: `faultRam`

## Requirements
- R1: Reset clears every cell to 0 and drives `rdData` to 0.
- R2: `rdData` in the cycle after an access holds the addressed cell's content from before that cycle's write, so a read of the address being written returns the old value.
- R3: With `cfgFault` 0 (none) or 7 (spare), the array behaves as an ideal RAM.
- R4: With `cfgFault` 1 (stuck-at), reads of the victim return `cfgForce`. Writes to the victim leave its stored content unchanged, and no other cell is affected.
- R5: With `cfgFault` 2 (transition), a victim write that would change it from 0 to 1 is blocked when `cfgPolUp`=1. A victim write from 1 to 0 is blocked when `cfgPolUp`=0. The opposite change and same-value writes take effect.
- R6: With `cfgFault` 3 (inversion coupling), a write that changes the aggressor to the value `cfgPolUp` also inverts the victim's stored content. A write leaving the aggressor unchanged, or changing it the other way, does not touch the victim.
- R7: With `cfgFault` 4 (idempotent coupling), the same aggressor trigger as R6 instead sets the victim to `cfgForce`.
- R8: With `cfgFault` 5 (state coupling), a read of the victim returns `cfgForce` whenever the aggressor cell holds `cfgPolUp`. Otherwise it returns the victim's stored content, which is preserved.
- R9: Coupling is one-way: in kinds 3 to 5, no access to the victim ever changes what the aggressor holds or reads.
- R10: With `cfgFault` 6 (decoder fault), a write to the aggressor address also writes the victim cell. A read of the aggressor address returns the AND of both cells. The victim address behaves normally.
- R11: For kinds 3 to 6, when the victim and aggressor are the same cell, the array behaves as an ideal RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Cell address for the read and any write |
| wrEn | input | 1 | Write strobe |
| wrData | input | 1 | Write value |
| rdData | output | 1 | Registered read value |
| cfgFault | input | 3 | Fault kind code (0 none, 1 stuck, 2 transition, 3 inversion, 4 idempotent, 5 state, 6 decoder, 7 spare) |
| cfgVictim | input | ADDR_W | Victim cell |
| cfgAggr | input | ADDR_W | Aggressor cell or aliasing address |
| cfgPolUp | input | 1 | Trigger direction (1 = rising), blocked transition, or coupling state |
| cfgForce | input | 1 | Value forced onto the victim |

## Verification
The write and the read of one address always share a cycle. In the coupling and decoder kinds, that write can also disturb a second cell in the same cycle. The sweeps therefore read each address in the very cycle it is written, including the aggressor address whose write flips, forces or aliases the victim. The expected value is the pre-write content, combined as the fault kind dictates; for the decoder kind this is the AND of the aggressor and victim contents before the write. A later read of the victim then shows the disturbance. Both results are judged against a bench model built from the requirements, over every fault code, both polarity and force values, and several victim and aggressor pairs including a coincident pair.

// File: rtl/faultRamPkg.sv
package faultRamPkg;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_STUCK  = 3'd1,
    FLT_TRANS  = 3'd2,
    FLT_INV    = 3'd3,
    FLT_IDEM   = 3'd4,
    FLT_STATE  = 3'd5,
    FLT_DECODE = 3'd6,
    FLT_SPARE  = 3'd7
  } faultKindT;

  // Strobes from the fault control to the cell array
  typedef struct packed {
    logic wrAddr;        // write the addressed cell
    logic wrAddrVal;
    logic wrVic;         // secondary write of the victim cell
    logic wrVicVal;
    logic rdOverride;    // replace the read value
    logic rdOverrideVal;
    logic rdAndVic;      // AND the victim into the read value
  } ramStrobeT;

endpackage

// File: rtl/faultRamCtrl.sv
module faultRamCtrl
  import faultRamPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              wrData,
  input  logic [2:0]        cfgFault,
  input  logic [ADDR_W-1:0] cfgVictim,
  input  logic [ADDR_W-1:0] cfgAggr,
  input  logic              cfgPolUp,
  input  logic              cfgForce,
  input  logic              curCell,
  input  logic              victimCell,
  input  logic              aggrCell,
  output ramStrobeT         strobe
);

  faultKindT kind;
  logic      hitVic;
  logic      hitAggr;
  logic      distinct;
  logic      aggrTrigger;

  assign kind        = faultKindT'(cfgFault);
  assign hitVic      = (addr == cfgVictim);
  assign hitAggr     = (addr == cfgAggr);
  assign distinct    = (cfgVictim != cfgAggr);
  // aggressor written with a change towards the configured direction
  assign aggrTrigger = wrEn && hitAggr && distinct &&
                       (curCell != wrData) && (wrData == cfgPolUp);

  always_comb begin
    strobe = '{wrAddr: wrEn, wrAddrVal: wrData, wrVic: 1'b0, wrVicVal: 1'b0,
               rdOverride: 1'b0, rdOverrideVal: 1'b0, rdAndVic: 1'b0};
    unique case (kind)
      FLT_STUCK: begin
        if (hitVic) begin
          strobe.wrAddr        = 1'b0;
          strobe.rdOverride    = 1'b1;
          strobe.rdOverrideVal = cfgForce;
        end
      end
      FLT_TRANS: begin
        if (wrEn && hitVic && (curCell != wrData) && (wrData == cfgPolUp))
          strobe.wrAddr = 1'b0;
      end
      FLT_INV: begin
        if (aggrTrigger) begin
          strobe.wrVic    = 1'b1;
          strobe.wrVicVal = ~victimCell;
        end
      end
      FLT_IDEM: begin
        if (aggrTrigger) begin
          strobe.wrVic    = 1'b1;
          strobe.wrVicVal = cfgForce;
        end
      end
      FLT_STATE: begin
        if (hitVic && distinct && (aggrCell == cfgPolUp)) begin
          strobe.rdOverride    = 1'b1;
          strobe.rdOverrideVal = cfgForce;
        end
      end
      FLT_DECODE: begin
        if (hitAggr && distinct) begin
          strobe.wrVic    = wrEn;
          strobe.wrVicVal = wrData;
          strobe.rdAndVic = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/faultRamArray.sv
module faultRamArray
  import faultRamPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] cfgVictim,
  input  logic [ADDR_W-1:0] cfgAggr,
  input  ramStrobeT         strobe,
  output logic              curCell,
  output logic              victimCell,
  output logic              aggrCell,
  output logic              rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] cells;
  logic             rdNext;

  assign curCell    = cells[addr];
  assign victimCell = cells[cfgVictim];
  assign aggrCell   = cells[cfgAggr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rstN)
        cells[i] <= 1'b0;
      else if (strobe.wrAddr && (addr == ADDR_W'(i)))
        cells[i] <= strobe.wrAddrVal;
      else if (strobe.wrVic && (cfgVictim == ADDR_W'(i)))
        cells[i] <= strobe.wrVicVal;
    end
  end

  always_comb begin
    if (strobe.rdOverride)
      rdNext = strobe.rdOverrideVal;
    else if (strobe.rdAndVic)
      rdNext = curCell & victimCell;
    else
      rdNext = curCell;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= 1'b0;
    else       rdData <= rdNext;
  end

endmodule

// File: rtl/faultRam.sv
module faultRam
  import faultRamPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              wrData,
  output logic              rdData,
  input  logic [2:0]        cfgFault,
  input  logic [ADDR_W-1:0] cfgVictim,
  input  logic [ADDR_W-1:0] cfgAggr,
  input  logic              cfgPolUp,
  input  logic              cfgForce
);

  ramStrobeT strobe;
  logic      curCell;
  logic      victimCell;
  logic      aggrCell;

  faultRamCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr      (addr),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .cfgFault  (cfgFault),
    .cfgVictim (cfgVictim),
    .cfgAggr   (cfgAggr),
    .cfgPolUp  (cfgPolUp),
    .cfgForce  (cfgForce),
    .curCell   (curCell),
    .victimCell(victimCell),
    .aggrCell  (aggrCell),
    .strobe    (strobe)
  );

  faultRamArray #(.ADDR_W(ADDR_W)) u_array (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .cfgVictim (cfgVictim),
    .cfgAggr   (cfgAggr),
    .strobe    (strobe),
    .curCell   (curCell),
    .victimCell(victimCell),
    .aggrCell  (aggrCell),
    .rdData    (rdData)
  );

endmodule

// File: rtl/faultRamChk.sv
module faultRamChk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              wrData,
  input logic              rdData,
  input logic [2:0]        cfgFault,
  input logic [ADDR_W-1:0] cfgVictim,
  input logic [ADDR_W-1:0] cfgAggr,
  input logic              cfgPolUp,
  input logic              cfgForce
);

  localparam int CFG_W = 3 + 2 * ADDR_W + 2;

  logic [CFG_W-1:0] cfgNow;
  logic [CFG_W-1:0] cfgPrev;
  logic [1:0]       quiet;
  logic             cfgSame;

  assign cfgNow  = {cfgFault, cfgVictim, cfgAggr, cfgPolUp, cfgForce};
  assign cfgSame = (cfgNow == cfgPrev);

  // edges since reset release with unchanged configuration, saturating
  always_ff @(posedge clk) begin
    cfgPrev <= cfgNow;
    if (!rstN)            quiet <= 2'd0;
    else if (!cfgSame)    quiet <= 2'd0;
    else if (quiet != 2'd3) quiet <= quiet + 2'd1;
  end

  // R3: ideal write followed by a read returns the written value
  assert_ideal_readback_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFault == 3'd0 && cfgSame && quiet >= 2'd1 && $past(wrEn) &&
     $past(addr) == addr && !wrEn)
    |=> rdData == $past(wrData, 2));

  // R4: stuck victim always reads the forced value
  assert_stuck_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFault == 3'd1 && addr == cfgVictim)
    |=> rdData == $past(cfgForce));

  // R5: a blocked transition write leaves the victim unchanged
  assert_trans_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFault == 3'd2 && cfgSame && quiet >= 2'd2 && addr == cfgVictim && !wrEn &&
     $past(addr) == cfgVictim && $past(wrEn) && $past(wrData) == cfgPolUp &&
     $past(addr, 2) == cfgVictim && !$past(wrEn, 2) && $past(rdData) != cfgPolUp)
    |=> rdData != $past(cfgPolUp));

  // R10: a write at the aliasing address also lands in the victim cell
  assert_decode_alias_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFault == 3'd6 && cfgSame && quiet >= 2'd1 && cfgVictim != cfgAggr &&
     $past(wrEn) && $past(addr) == cfgAggr && addr == cfgVictim && !wrEn)
    |=> rdData == $past(wrData, 2));

endmodule

bind faultRam faultRamChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addr     (addr),
  .wrEn     (wrEn),
  .wrData   (wrData),
  .rdData   (rdData),
  .cfgFault (cfgFault),
  .cfgVictim(cfgVictim),
  .cfgAggr  (cfgAggr),
  .cfgPolUp (cfgPolUp),
  .cfgForce (cfgForce)
);

// File: tb/faultRam_tb.sv
`timescale 1ns/1ps
module faultRam_tb;

  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addr;
  logic          wrEn;
  logic          wrData;
  logic          rdData;
  logic [2:0]    cfgFault;
  logic [AW-1:0] cfgVictim;
  logic [AW-1:0] cfgAggr;
  logic          cfgPolUp;
  logic          cfgForce;

  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  logic refMem [N];

  always #4 clk = ~clk;

  faultRam #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .cfgFault(cfgFault), .cfgVictim(cfgVictim),
    .cfgAggr(cfgAggr), .cfgPolUp(cfgPolUp), .cfgForce(cfgForce)
  );

  function automatic logic modelRead(int a);
    int v  = int'(cfgVictim);
    int ag = int'(cfgAggr);
    case (cfgFault)
      3'd1: if (a == v) return cfgForce;
      3'd5: if (a == v && v != ag && refMem[ag] == cfgPolUp) return cfgForce;
      3'd6: if (a == ag && ag != v) return refMem[a] & refMem[v];
      default: ;
    endcase
    return refMem[a];
  endfunction

  function automatic void modelWrite(int a, logic d);
    int   v   = int'(cfgVictim);
    int   ag  = int'(cfgAggr);
    logic old = refMem[a];
    case (cfgFault)
      3'd1: if (a != v) refMem[a] = d;
      3'd2: if (!(a == v && old != d && d == cfgPolUp)) refMem[a] = d;
      3'd3, 3'd4: begin
        refMem[a] = d;
        if (a == ag && ag != v && old != d && d == cfgPolUp)
          refMem[v] = (cfgFault == 3'd3) ? ~refMem[v] : cfgForce;
      end
      3'd6: begin
        refMem[a] = d;
        if (a == ag && ag != v) refMem[v] = d;
      end
      default: refMem[a] = d;
    endcase
  endfunction

  function automatic string tagFor(int a);
    int v  = int'(cfgVictim);
    int ag = int'(cfgAggr);
    if (cfgFault >= 3'd3 && cfgFault <= 3'd5 && a == ag && ag != v) return "R9";
    if (cfgFault >= 3'd3 && cfgFault <= 3'd6 && ag == v) return "R11";
    case (cfgFault)
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R10";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp, int a);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s kind=%0d vic=%0d agg=%0d pol=%0b frc=%0b addr=%0d actual=%0b expected=%0b",
               tag, cfgFault, cfgVictim, cfgAggr, cfgPolUp, cfgForce, a, act, exp);
    end
  endtask

  // called at a falling edge; checks the read of this access one cycle later
  task automatic op(int a, logic we, logic d, string tagIn);
    logic  exp;
    string tag;
    exp = modelRead(a);
    tag = (tagIn != "") ? tagIn : tagFor(a);
    addr   = a[AW-1:0];
    wrEn   = we;
    wrData = d;
    if (we) modelWrite(a, d);
    @(negedge clk);
    wrEn = 1'b0;
    check(tag, rdData, exp, a);
  endtask

  task automatic setCfg(int k, int v, int ag, logic p, logic f);
    wrEn      = 1'b0;
    cfgFault  = k[2:0];
    cfgVictim = v[AW-1:0];
    cfgAggr   = ag[AW-1:0];
    cfgPolUp  = p;
    cfgForce  = f;
    @(negedge clk);
  endtask

  initial begin
    int vics [4] = '{3, 9, 5, 0};
    int aggs [4] = '{9, 3, 5, 15};
    rstN = 1'b0; addr = '0; wrEn = 1'b0; wrData = 1'b0;
    cfgFault = 3'd0; cfgVictim = '0; cfgAggr = '0; cfgPolUp = 1'b0; cfgForce = 1'b0;
    for (int i = 0; i < N; i++) refMem[i] = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", rdData, 1'b0, 0);
    rstN = 1'b1;
    for (int a = 0; a < N; a++) op(a, 1'b0, 1'b0, "R1");

    // R2: same-cycle write and read returns the old content
    op(5, 1'b1, 1'b1, "R2");
    op(5, 1'b0, 1'b0, "R2");
    op(5, 1'b1, 1'b0, "R2");
    op(5, 1'b0, 1'b0, "R2");

    for (int k = 0; k < 8; k++)
      for (int pi = 0; pi < 4; pi++)
        for (int p = 0; p < 2; p++)
          for (int f = 0; f < 2; f++) begin
            setCfg(k, vics[pi], aggs[pi], p[0], f[0]);
            for (int a = 0; a < N; a++) op(a, 1'b1, logic'((a + k + pi + p) % 2), "");
            for (int a = 0; a < N; a++) begin
              op(a, 1'b0, 1'b0, "");
              op(a, 1'b1, 1'b1, "");
              op(a, 1'b0, 1'b0, "");
              op(a, 1'b1, 1'b0, "");
              op(a, 1'b0, 1'b0, "");
            end
            for (int a = N - 1; a >= 0; a--) begin
              op(a, 1'b1, 1'b1, "");
              op(a, 1'b0, 1'b0, "");
            end
          end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule